// File: doc/BRIEF.md
# Windowed Offset and AC-Load Fault Qualifier

This block decides two per-channel speaker faults from the behaviour of comparator flags over a window that the host opens and closes. A DC offset fault is raised only if the excess-offset comparator stayed high during every cycle of the window. An AC-coupled-load fault (missing tweeter) is raised when too few current peaks above the selected threshold were seen during the window.

A window opens at each host read, or when the matching test enable rises. It closes at the next read. The read strobe latches both verdicts into the output bits and opens the next window in the same cycle. If the short-circuit protection fires on a channel during a window, both tests on that channel are abandoned for that window and report no fault.

All comparator and overload flags are asynchronous. Each passes through a two-stage synchroniser, so a flag driven during cycle n takes part in the window from cycle n+2 onward.

Top module: `diag_window_qual`

## Requirements
- R1: After reset, `offsetFault` and `openLoad` are all zero.
- R2: `offsetFault` and `openLoad` change only on the clock edge that ends a cycle in which `readStb` is high. Between reads they hold their value.
- R3: On a read with `offsetEn` high, a channel's `offsetFault` becomes 1 only if its synchronised `offsetHigh` was high in every cycle from the window opening through the cycle before the read, and no overload occurred. A single low cycle clears the verdict.
- R4: A rising edge of `offsetEn` restarts the offset window, so low cycles of `offsetHigh` before that edge do not count.
- R5: Current pulses are counted on rising edges of the synchronised peak flag. `thrSel`=0 selects `peakHi` (the higher threshold pair) and `thrSel`=1 selects `peakLo`. A flag held high counts once.
- R6: On a read with `acEn` high, a channel's `openLoad` becomes 1 when fewer than 3 pulses were counted in the window, and 0 when 3 or more were counted.
- R7: A rising edge of `acEn` restarts the pulse count, so pulses before that edge do not count.
- R8: If a channel's `overload` is seen in any cycle of the window, both of that channel's verdicts at the read are 0.
- R9: A read with `offsetEn` low gives `offsetFault` = 0, and a read with `acEn` low gives `openLoad` = 0, whatever the flags did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offsetEn | input | 1 | Enables the DC offset test; a rising edge opens a window |
| acEn | input | 1 | Enables the AC load test; a rising edge opens a window |
| thrSel | input | 1 | Peak threshold pair select: 0 high pair, 1 low pair |
| readStb | input | 1 | Host read: latches the verdicts and opens a new window |
| offsetHigh | input | NCH | Per-channel excess DC offset comparator (asynchronous) |
| peakHi | input | NCH | Per-channel current above the high normal threshold (asynchronous) |
| peakLo | input | NCH | Per-channel current above the low normal threshold (asynchronous) |
| overload | input | NCH | Per-channel short-circuit protection active (asynchronous) |
| offsetFault | output | NCH | Latched DC offset fault per channel |
| openLoad | output | NCH | Latched open tweeter verdict per channel |

## Verification
The bound checker watches four things on every cycle:
- the outputs stay still outside read edges;
- a disabled test reports nothing;
- an overload seen in the window suppresses both verdicts;
- an offset verdict is never raised after a low flag in the last window cycle.

Pulse counting needs whole scenarios. This includes the threshold-select routing, a held flag counting once, the saturating count of three, and window restarts on enable edges. The bench shows these with directed windows, and with random windows checked against a cycle model.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  typedef struct packed {
    logic latch;      // read edge: capture verdicts
    logic openOff;    // start a fresh offset window
    logic openAc;     // start a fresh pulse-count window
    logic reportOff;  // offset test enabled at capture
    logic reportAc;   // AC test enabled at capture
  } winCtrl_t;
endpackage

// File: rtl/dwq_sync.sv
module dwq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dwq_ctrl.sv
module dwq_ctrl
  import dwq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     offsetEn,
  input  logic     acEn,
  input  logic     readStb,
  output winCtrl_t ctrl
);
  logic offEnQ, acEnQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offEnQ <= 1'b0;
      acEnQ  <= 1'b0;
    end else begin
      offEnQ <= offsetEn;
      acEnQ  <= acEn;
    end
  end

  always_comb begin
    ctrl.latch     = readStb;
    ctrl.openOff   = readStb | (offsetEn & ~offEnQ);
    ctrl.openAc    = readStb | (acEn & ~acEnQ);
    ctrl.reportOff = offsetEn;
    ctrl.reportAc  = acEn;
  end
endmodule

// File: rtl/dwq_datapath.sv
module dwq_datapath
  import dwq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int PULSE_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  winCtrl_t       ctrl,
  input  logic           thrSel,
  input  logic [NCH-1:0] offS,
  input  logic [NCH-1:0] hiS,
  input  logic [NCH-1:0] loS,
  input  logic [NCH-1:0] ovS,
  output logic [NCH-1:0] offsetFault,
  output logic [NCH-1:0] openLoad
);
  localparam int CNT_W = $clog2(PULSE_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PULSE_MIN);

  for (genvar i = 0; i < NCH; i++) begin : gCh
    logic selNow, selPrev, pulse;
    logic persist, aborted;
    logic [CNT_W-1:0] cnt;

    assign selNow = thrSel ? loS[i] : hiS[i];
    assign pulse  = selNow & ~selPrev;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        selPrev        <= 1'b0;
        persist        <= 1'b0;
        aborted        <= 1'b0;
        cnt            <= '0;
        offsetFault[i] <= 1'b0;
        openLoad[i]    <= 1'b0;
      end else begin
        selPrev <= selNow;
        // persistence: the opening cycle's sample seeds the window
        if (ctrl.openOff) persist <= offS[i];
        else              persist <= persist & offS[i];
        // saturating pulse counter
        if (ctrl.openAc)                       cnt <= pulse ? CNT_W'(1) : '0;
        else if (pulse && (cnt < CNT_MAX))     cnt <= cnt + CNT_W'(1);
        // overload aborts the window in progress
        if (ctrl.latch) begin
          aborted        <= ovS[i];
          offsetFault[i] <= ctrl.reportOff & persist & ~aborted;
          openLoad[i]    <= ctrl.reportAc & ~aborted & (cnt < CNT_MAX);
        end else begin
          aborted <= aborted | ovS[i];
        end
      end
    end
  end
endmodule

// File: rtl/diag_window_qual.sv
module diag_window_qual
  import dwq_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int PULSE_MIN   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           offsetEn,
  input  logic           acEn,
  input  logic           thrSel,
  input  logic           readStb,
  input  logic [NCH-1:0] offsetHigh,
  input  logic [NCH-1:0] peakHi,
  input  logic [NCH-1:0] peakLo,
  input  logic [NCH-1:0] overload,
  output logic [NCH-1:0] offsetFault,
  output logic [NCH-1:0] openLoad
);
  localparam int SW = 4 * NCH;

  winCtrl_t       ctrl;
  logic [SW-1:0]  syncOut;

  dwq_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({overload, peakLo, peakHi, offsetHigh}),
    .dout (syncOut)
  );

  dwq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .offsetEn(offsetEn),
    .acEn    (acEn),
    .readStb (readStb),
    .ctrl    (ctrl)
  );

  dwq_datapath #(.NCH(NCH), .PULSE_MIN(PULSE_MIN)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .thrSel     (thrSel),
    .offS       (syncOut[NCH-1:0]),
    .hiS        (syncOut[2*NCH-1:NCH]),
    .loS        (syncOut[3*NCH-1:2*NCH]),
    .ovS        (syncOut[4*NCH-1:3*NCH]),
    .offsetFault(offsetFault),
    .openLoad   (openLoad)
  );
endmodule

// File: rtl/dwq_checks.sv
module dwq_checks #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           offsetEn,
  input logic           acEn,
  input logic           readStb,
  input logic [NCH-1:0] offsetHigh,
  input logic [NCH-1:0] overload,
  input logic [NCH-1:0] offsetFault,
  input logic [NCH-1:0] openLoad
);
  // four-cycle delay lines of the raw flags (two sync stages + state + output)
  logic [NCH-1:0] ovD [4];
  logic [NCH-1:0] offD [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        ovD[k]  <= '0;
        offD[k] <= '0;
      end
    end else begin
      ovD[0]  <= overload;
      offD[0] <= offsetHigh;
      for (int k = 1; k < 4; k++) begin
        ovD[k]  <= ovD[k-1];
        offD[k] <= offD[k-1];
      end
    end
  end

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !readStb |=> $stable(offsetFault));
  assert_hold_ac_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !readStb |=> $stable(openLoad));
  assert_off_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readStb && !offsetEn) |=> (offsetFault == '0));
  assert_ac_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readStb && !acEn) |=> (openLoad == '0));
  assert_overload_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    readStb |=> (((offsetFault | openLoad) & ovD[3]) == '0));
  assert_offset_persist_R3: assert property (@(posedge clk) disable iff (!rst_n)
    readStb |=> ((offsetFault & ~offD[3]) == '0));
endmodule

bind diag_window_qual dwq_checks #(.NCH(NCH)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .offsetEn   (offsetEn),
  .acEn       (acEn),
  .readStb    (readStb),
  .offsetHigh (offsetHigh),
  .overload   (overload),
  .offsetFault(offsetFault),
  .openLoad   (openLoad)
);

// File: tb/tb_diag_window_qual.sv
module tb_diag_window_qual;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offsetEn = 0, acEn = 0, thrSel = 0, readStb = 0;
  logic [NCH-1:0] offsetHigh = '0, peakHi = '0, peakLo = '0, overload = '0;
  logic [NCH-1:0] offsetFault, openLoad;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  diag_window_qual #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .offsetEn(offsetEn), .acEn(acEn), .thrSel(thrSel),
    .readStb(readStb), .offsetHigh(offsetHigh), .peakHi(peakHi), .peakLo(peakLo),
    .overload(overload), .offsetFault(offsetFault), .openLoad(openLoad)
  );

  // cycle model of the requirements
  logic [NCH-1:0] mOff1, mOff2, mHi1, mHi2, mLo1, mLo2, mOv1, mOv2;
  logic [NCH-1:0] mPrev, mPersist, mAbort, mExpOff, mExpOpen;
  int mCnt [NCH];
  logic mOffEnQ, mAcEnQ;

  function automatic logic [NCH-1:0] expOffsetVerdict(logic en, logic [NCH-1:0] pers,
                                                      logic [NCH-1:0] ab);
    return en ? (pers & ~ab) : '0;
  endfunction

  task automatic modelReset();
    {mOff1, mOff2, mHi1, mHi2, mLo1, mLo2, mOv1, mOv2} = '0;
    {mPrev, mPersist, mAbort, mExpOff, mExpOpen} = '0;
    for (int c = 0; c < NCH; c++) mCnt[c] = 0;
    mOffEnQ = 0; mAcEnQ = 0;
  endtask

  task automatic modelStep();
    logic [NCH-1:0] sel, pulse, nOpen;
    logic openOff, openAc;
    sel     = thrSel ? mLo2 : mHi2;
    pulse   = sel & ~mPrev;
    openOff = readStb | (offsetEn & ~mOffEnQ);
    openAc  = readStb | (acEn & ~mAcEnQ);
    if (readStb) begin
      mExpOff = expOffsetVerdict(offsetEn, mPersist, mAbort);
      for (int c = 0; c < NCH; c++) nOpen[c] = acEn & ~mAbort[c] & (mCnt[c] < 3);
      mExpOpen = nOpen;
      mAbort   = mOv2;
    end else begin
      mAbort = mAbort | mOv2;
    end
    mPersist = openOff ? mOff2 : (mPersist & mOff2);
    for (int c = 0; c < NCH; c++) begin
      if (openAc)                     mCnt[c] = pulse[c] ? 1 : 0;
      else if (pulse[c] && mCnt[c] < 3) mCnt[c] = mCnt[c] + 1;
    end
    mPrev = sel;
    mOff2 = mOff1; mHi2 = mHi1; mLo2 = mLo1; mOv2 = mOv1;
    mOff1 = offsetHigh; mHi1 = peakHi; mLo1 = peakLo; mOv1 = overload;
    mOffEnQ = offsetEn; mAcEnQ = acEn;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) modelStep(); else modelReset();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic doRead();
    readStb = 1; step(); readStb = 0;
  endtask

  task automatic check(string tag, logic [NCH-1:0] got, logic [NCH-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulses(int n, logic useLo);
    for (int k = 0; k < n; k++) begin
      if (useLo) peakLo = '1; else peakHi = '1;
      idle(2);
      if (useLo) peakLo = '0; else peakHi = '0;
      idle(2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    idle(5);
    check("R1 reset offsetFault", offsetFault, '0);
    check("R1 reset openLoad", openLoad, '0);
    rst_n = 1;
    idle(2);
    doRead();

    // R4: low offset cycles before the enable edge are forgotten
    offsetHigh = '0; idle(3);
    offsetHigh = '1; idle(4);
    offsetEn = 1; idle(8);
    doRead();
    check("R4 window reopened by enable edge", offsetFault, 4'hF);
    check("R9 AC disabled", openLoad, 4'h0);

    // R2: outputs hold while flags move between reads
    offsetHigh = 4'h0; peakHi = 4'hF; idle(6);
    check("R2 hold between reads", offsetFault, 4'hF);
    offsetHigh = 4'hF; peakHi = 4'h0; idle(4);
    doRead();   // window contained low cycles
    idle(4);
    // R3: one low cycle on channel 0 spoils the window
    offsetHigh = 4'hE; idle(1); offsetHigh = 4'hF; idle(8);
    doRead();
    check("R3 single low cycle clears", offsetFault, 4'hE);
    idle(10);
    doRead();
    check("R3 persistent offset", offsetFault, 4'hF);

    // R9: offset disabled
    offsetEn = 0; idle(6);
    doRead();
    check("R9 offset disabled", offsetFault, 4'h0);

    // R6, R5: thrSel=0, three versus two pulses on peakHi
    acEn = 1; thrSel = 0; idle(3);
    pulses(3, 0); idle(3);
    doRead();
    check("R6 three pulses present", openLoad, 4'h0);
    idle(2); pulses(2, 0); idle(3);
    doRead();
    check("R6 two pulses open", openLoad, 4'hF);
    idle(2); pulses(5, 0); idle(3);
    doRead();
    check("R6 count saturates no wrap", openLoad, 4'h0);

    // R5: held flag counts once
    idle(2); peakHi = '1; idle(12); peakHi = '0; idle(3);
    doRead();
    check("R5 held flag counts once", openLoad, 4'hF);

    // R5: thrSel=1 routes peakLo, ignores peakHi
    thrSel = 1; idle(2); doRead();
    idle(2); pulses(3, 1); idle(3);
    doRead();
    check("R5 low pair counted", openLoad, 4'h0);
    idle(2); pulses(3, 0); idle(3);
    doRead();
    check("R5 high pair ignored when thrSel=1", openLoad, 4'hF);
    thrSel = 0;

    // R7: pulses before the acEn edge are dropped
    acEn = 0; idle(2); doRead();
    idle(2); pulses(3, 0);
    acEn = 1; idle(2); pulses(2, 0); idle(3);
    doRead();
    check("R7 window reopened by acEn edge", openLoad, 4'hF);

    // R8: overload on channel 1 aborts both tests
    offsetEn = 1; offsetHigh = '1; idle(4); doRead();
    idle(3); overload = 4'h2; idle(1); overload = 4'h0;
    pulses(1, 0); idle(6);
    doRead();
    check("R8 overload aborts offset", offsetFault, 4'hD);
    check("R8 overload aborts AC", openLoad, 4'hD);

    // random windows against the model (R3 R5 R6 R8)
    for (int w = 0; w < 120; w++) begin
      int len = 8 + int'($urandom_range(0, 30));
      if ($urandom_range(0, 5) == 0) offsetEn = ~offsetEn;
      if ($urandom_range(0, 5) == 0) acEn = ~acEn;
      if ($urandom_range(0, 7) == 0) thrSel = ~thrSel;
      for (int k = 0; k < len; k++) begin
        for (int c = 0; c < NCH; c++) begin
          offsetHigh[c] = ($urandom_range(0, 40) != 0);
          peakHi[c]     = ($urandom_range(0, 4) == 0);
          peakLo[c]     = ($urandom_range(0, 3) == 0);
          overload[c]   = ($urandom_range(0, 300) == 0);
        end
        step();
      end
      doRead();
      check("R3 R9 random offset", offsetFault, mExpOff);
      check("R5 R6 R8 random open", openLoad, mExpOpen);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule